// File: doc/BRIEF.md
# Dual-Rail Soft-Start Reference Sequencer

This block brings up two regulated outputs, a core rail and an auxiliary rail, in a fixed order. Enable and a power-on-ready input must both be high before anything starts. The block then samples both target codes and the mode select, and holds them. After a fixed delay it raises a digital reference for each rail toward its target at a constant slew. The analog loop compares each reference with the sensed output. The comparator result comes back as a flag, and the block uses that flag to decide when each rail's power stage may switch.

The references are codes with a 0.25 mV LSB. Once every microsecond, each active reference gains `STEP` LSBs. The default of 13 gives 3.25 mV/µs, and a reference never rises past its target. The microsecond tick is made from a parameter that gives clock cycles per microsecond. A rail whose output is already charged above the rising reference keeps its drivers off until the reference passes the output. If the output starts above the final target, the drivers stay off until soft-start completes. In parallel mode the auxiliary rail is left off and only the core rail ramps. Power-good goes high once every active reference has reached its target.

Top module: `ss_seq`

## Requirements
- R1: On the first clock edge where `en` and `por_ok` are both high, the sequencer samples `tgt_core`, `tgt_aux` and `par_mode`. Later changes on these inputs have no effect until the sequence is aborted.
- R2: After the sampling edge, both references stay at 0 for `DELAY_US` microsecond ticks. One tick occurs every `CYC_PER_US` clock edges.
- R3: After the delay, each microsecond tick raises every active reference by `STEP` codes. The result is clamped at that rail's sampled target, so a reference never exceeds its target.
- R4: During the delay and the ramp, a rail's driver enable stays low on every edge where its `above_*` flag is 1. A flag of 1 means the sensed output is above the reference.
- R5: On the first edge during the ramp or done phase where an active rail's `above_*` flag is 0, that rail's driver enable rises. It then stays high until the sequence is aborted.
- R6: If a rail's flag never falls, for example because the output is pre-charged above the target, its driver enable rises on the edge after power-good rises.
- R7: `pgood` rises on the clock edge after the edge on which the last active reference reaches its target. It stays high while `en` and `por_ok` remain high.
- R8: When `par_mode` was sampled as 1, `ref_aux` stays 0 and `drv_aux` stays low. The ramp length and power-good then depend on the core rail only.
- R9: An edge that samples `en` or `por_ok` low clears both references, both driver enables and `pgood`. It also returns the sequencer to idle, ready to sample again.
- R10: While `rst_n` is low, both references are 0 and the driver enables and `pgood` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sequence enable |
| por_ok | input | 1 | Power-on-ready condition |
| par_mode | input | 1 | 1 = parallel mode, auxiliary rail disabled |
| tgt_core | input | CODE_W | Core target code, 0.25 mV LSB |
| tgt_aux | input | CODE_W | Auxiliary target code, 0.25 mV LSB |
| above_core | input | 1 | 1 = core output sensed above `ref_core` |
| above_aux | input | 1 | 1 = auxiliary output sensed above `ref_aux` |
| ref_core | output | CODE_W | Core ramping reference code |
| ref_aux | output | CODE_W | Auxiliary ramping reference code |
| drv_core | output | 1 | Core driver enable |
| drv_aux | output | 1 | Auxiliary driver enable |
| pgood | output | 1 | Both active ramps complete |

## Verification
The targets are swept over a grid of core and auxiliary values. The grid includes 0, values just below, at and just above multiples of the step, and the largest code. These values separate a wrong clamp, a missing or extra tick, and a wrong choice of which rail finishes last. Each sweep runs in both modes, so that dropping the auxiliary rail from the completion test is visible.

The modelled pre-charge level varies from 0, through mid-ramp, to above the target. This separates immediate release, release on crossing, and release only at completion. Further runs change the target inputs mid-sequence, and abort through either qualifying input in the middle of the ramp.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    SS_IDLE  = 2'd0,
    SS_DELAY = 2'd1,
    SS_RAMP  = 2'd2,
    SS_DONE  = 2'd3
  } ss_state_e;

  localparam int unsigned NUM_RAILS = 2;
endpackage

// File: rtl/ss_tick.sv
module ss_tick #(
  parameter int unsigned CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_PER_US - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import ss_pkg::*;
#(
  parameter int unsigned DELAY_US = 100
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  logic      tick,
  input  logic      all_at_tgt,
  output ss_state_e state
);
  localparam int unsigned DLY_W = (DELAY_US > 1) ? $clog2(DELAY_US) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_US - 1);

  ss_state_e        state_q, state_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             dly_en;

  assign state  = state_q;
  assign dly_en = (state_q == SS_DELAY) && tick;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    if (!go) begin
      state_d = SS_IDLE;
      dly_d   = '0;
    end else begin
      unique case (state_q)
        SS_IDLE: begin
          state_d = SS_DELAY;
          dly_d   = '0;
        end
        SS_DELAY: begin
          if (dly_en) begin
            if (dly_q == DLY_LAST) begin
              state_d = SS_RAMP;
            end else begin
              dly_d = dly_q + DLY_W'(1);
            end
          end
        end
        SS_RAMP: begin
          if (all_at_tgt) begin
            state_d = SS_DONE;
          end
        end
        SS_DONE: state_d = SS_DONE;
        default: state_d = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SS_IDLE;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
    end
  end
endmodule

// File: rtl/ss_rail.sv
module ss_rail
  import ss_pkg::*;
#(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned STEP   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  ss_state_e         state,
  input  logic              tick,
  input  logic              act_in,
  input  logic [CODE_W-1:0] tgt_in,
  input  logic              above,
  output logic [CODE_W-1:0] ref_o,
  output logic              drv_o,
  output logic              at_tgt,
  output logic [CODE_W-1:0] tgt_held,
  output logic              act_held
);
  localparam logic [CODE_W:0] STEP_EXT = (CODE_W+1)'(STEP);

  logic [CODE_W-1:0] tgt_q, tgt_d, ref_q, ref_d;
  logic              act_q, act_d, drv_q, drv_d;
  logic              capture, step_en, release_en;
  logic [CODE_W:0]   sum;

  assign capture    = go && (state == SS_IDLE);
  assign step_en    = act_q && (state == SS_RAMP) && tick;
  assign release_en = act_q && (((state == SS_RAMP) && !above) || (state == SS_DONE));
  assign sum        = {1'b0, ref_q} + STEP_EXT;

  always_comb begin
    tgt_d = tgt_q;
    act_d = act_q;
    if (capture) begin
      tgt_d = tgt_in;
      act_d = act_in;
    end
  end

  always_comb begin
    ref_d = ref_q;
    drv_d = drv_q;
    if (!go) begin
      ref_d = '0;
      drv_d = 1'b0;
    end else begin
      if (step_en) begin
        ref_d = (sum > {1'b0, tgt_q}) ? tgt_q : sum[CODE_W-1:0];
      end
      if (release_en) begin
        drv_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      act_q <= 1'b0;
      ref_q <= '0;
      drv_q <= 1'b0;
    end else begin
      tgt_q <= tgt_d;
      act_q <= act_d;
      ref_q <= ref_d;
      drv_q <= drv_d;
    end
  end

  assign ref_o    = ref_q;
  assign drv_o    = drv_q;
  assign at_tgt   = !act_q || (ref_q == tgt_q);
  assign tgt_held = tgt_q;
  assign act_held = act_q;
endmodule

// File: rtl/ss_seq.sv
module ss_seq
  import ss_pkg::*;
#(
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned STEP       = 13,
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned DELAY_US   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              por_ok,
  input  logic              par_mode,
  input  logic [CODE_W-1:0] tgt_core,
  input  logic [CODE_W-1:0] tgt_aux,
  input  logic              above_core,
  input  logic              above_aux,
  output logic [CODE_W-1:0] ref_core,
  output logic [CODE_W-1:0] ref_aux,
  output logic              drv_core,
  output logic              drv_aux,
  output logic              pgood
);
  logic              go, tick, all_at_tgt;
  ss_state_e         state;
  logic [CODE_W-1:0] tgt_in   [NUM_RAILS];
  logic [CODE_W-1:0] ref_r    [NUM_RAILS];
  logic [CODE_W-1:0] tgt_q    [NUM_RAILS];
  logic              act_in   [NUM_RAILS];
  logic              above_in [NUM_RAILS];
  logic              drv_r    [NUM_RAILS];
  logic              act_q    [NUM_RAILS];
  logic [NUM_RAILS-1:0] done_r;

  assign go = en && por_ok;

  assign tgt_in[0]   = tgt_core;
  assign tgt_in[1]   = tgt_aux;
  assign act_in[0]   = 1'b1;
  assign act_in[1]   = !par_mode;
  assign above_in[0] = above_core;
  assign above_in[1] = above_aux;

  ss_tick #(.CYC_PER_US(CYC_PER_US)) i_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state != SS_IDLE),
    .tick (tick)
  );

  ss_ctrl #(.DELAY_US(DELAY_US)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .tick      (tick),
    .all_at_tgt(all_at_tgt),
    .state     (state)
  );

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    ss_rail #(.CODE_W(CODE_W), .STEP(STEP)) i_rail (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .state   (state),
      .tick    (tick),
      .act_in  (act_in[r]),
      .tgt_in  (tgt_in[r]),
      .above   (above_in[r]),
      .ref_o   (ref_r[r]),
      .drv_o   (drv_r[r]),
      .at_tgt  (done_r[r]),
      .tgt_held(tgt_q[r]),
      .act_held(act_q[r])
    );
  end

  assign all_at_tgt = &done_r;
  assign ref_core   = ref_r[0];
  assign ref_aux    = ref_r[1];
  assign drv_core   = drv_r[0];
  assign drv_aux    = drv_r[1];
  assign pgood      = (state == SS_DONE);
endmodule

// File: rtl/ss_chk.sv
module ss_chk
  import ss_pkg::*;
#(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned STEP   = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              por_ok,
  input logic              above_core,
  input logic [CODE_W-1:0] ref_core,
  input logic [CODE_W-1:0] ref_aux,
  input logic              drv_core,
  input logic              drv_aux,
  input logic              pgood,
  input ss_state_e         state,
  input logic [CODE_W-1:0] tgt_core_q,
  input logic [CODE_W-1:0] tgt_aux_q,
  input logic              aux_act_q
);
  // R9: a dropped qualifier clears every output on the next edge
  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && por_ok) |=> (ref_core == '0) && (ref_aux == '0) && !drv_core && !drv_aux && !pgood);

  // R2: references stay at zero through the delay phase
  a_r2_delay_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SS_DELAY) |-> (ref_core == '0) && (ref_aux == '0));

  // R3: the core reference rises by at most one step per edge and never exceeds its target
  a_r3_core_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && por_ok && state != SS_IDLE) |=>
      (ref_core >= $past(ref_core)) && ((ref_core - $past(ref_core)) <= CODE_W'(STEP)));

  a_r3_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_core <= tgt_core_q) && (ref_aux <= tgt_aux_q));

  // R4: the driver stays off while the flag is high before release
  a_r4_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_core && above_core && state != SS_DONE) |=> !drv_core);

  // R5: the driver enable is sticky while qualified
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_core && en && por_ok) |=> drv_core);

  // R7: power-good implies every active reference is at its target, and it holds
  a_r7_pg_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (ref_core == tgt_core_q) && (!aux_act_q || ref_aux == tgt_aux_q));

  a_r7_pg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood && en && por_ok) |=> pgood);

  // R8: an inactive auxiliary rail stays off
  a_r8_aux_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!aux_act_q && state != SS_IDLE) |-> (ref_aux == '0) && !drv_aux);
endmodule

bind ss_seq ss_chk #(.CODE_W(CODE_W), .STEP(STEP)) i_ss_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .por_ok    (por_ok),
  .above_core(above_core),
  .ref_core  (ref_core),
  .ref_aux   (ref_aux),
  .drv_core  (drv_core),
  .drv_aux   (drv_aux),
  .pgood     (pgood),
  .state     (state),
  .tgt_core_q(tgt_q[0]),
  .tgt_aux_q (tgt_q[1]),
  .aux_act_q (act_q[1])
);

// File: tb/test_ss_seq.sv
`timescale 1ns/1ps
module test_ss_seq;
  localparam int CODE_W = 10;
  localparam int STEP   = 13;
  localparam int CYC    = 2;
  localparam int DLY    = 3;
  localparam int MAXC   = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n, en, por_ok, par_mode;
  logic [CODE_W-1:0] tgt_core, tgt_aux;
  logic              above_core, above_aux;
  logic [CODE_W-1:0] ref_core, ref_aux;
  logic              drv_core, drv_aux, pgood;

  int checks = 0;
  int errors = 0;
  int pc_core = 0;
  int pc_aux  = 0;
  int cyc_cnt = 0;

  always #2.5 clk = ~clk;

  // comparator model: sensed output held at a pre-charge level
  assign above_core = (pc_core > int'(ref_core));
  assign above_aux  = (pc_aux  > int'(ref_aux));

  ss_seq #(.CODE_W(CODE_W), .STEP(STEP), .CYC_PER_US(CYC), .DELAY_US(DLY)) i_ss_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .por_ok(por_ok), .par_mode(par_mode),
    .tgt_core(tgt_core), .tgt_aux(tgt_aux), .above_core(above_core), .above_aux(above_aux),
    .ref_core(ref_core), .ref_aux(ref_aux), .drv_core(drv_core), .drv_aux(drv_aux),
    .pgood(pgood)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_ref(input int n, input int tgt);
    int k;
    k = n / CYC - DLY;
    if (k <= 0) return 0;
    return (STEP * k > tgt) ? tgt : STEP * k;
  endfunction

  function automatic int ramp_ticks(input int tgt);
    return (tgt + STEP - 1) / STEP;
  endfunction

  function automatic int drv_on(input int tgt, input int pc, input int ndone);
    for (int m = DLY * CYC; m < ndone; m++) begin
      if (exp_ref(m, tgt) >= pc) return m + 1;
    end
    return ndone + 1;
  endfunction

  // one full sequence; n counts edges after the sampling edge
  task automatic run_seq(input int tc, input int ta, input bit pm,
                         input int pcc, input int pca, input bit disturb);
    int jc, ja, nd, onc, ona;
    jc  = ramp_ticks(tc);
    ja  = pm ? 0 : ramp_ticks(ta);
    nd  = (DLY + ((jc > ja) ? jc : ja)) * CYC + 1;
    onc = drv_on(tc, pcc, nd);
    ona = drv_on(ta, pca, nd);
    @(negedge clk);
    pc_core = pcc; pc_aux = pca;
    tgt_core = CODE_W'(tc); tgt_aux = CODE_W'(ta); par_mode = pm;
    en = 1'b1; por_ok = 1'b1;
    @(posedge clk);
    for (int n = 0; n <= nd + 2; n++) begin
      @(negedge clk);
      if (disturb && n == 2) begin
        tgt_core = CODE_W'(MAXC - tc); tgt_aux = CODE_W'(MAXC - ta); par_mode = !pm;
      end
      chk(n < DLY * CYC ? "R2 delay ref_core" : "R3 ref_core", int'(ref_core), exp_ref(n, tc));
      chk(pm ? "R8 ref_aux off" : "R3 ref_aux", int'(ref_aux), pm ? 0 : exp_ref(n, ta));
      chk(pcc > tc ? "R6 drv_core" : "R4/R5 drv_core", int'(drv_core), int'(n >= onc));
      chk(pm ? "R8 drv_aux off" : (pca > ta ? "R6 drv_aux" : "R4/R5 drv_aux"),
          int'(drv_aux), pm ? 0 : int'(n >= ona));
      chk(disturb ? "R1 frozen pgood" : "R7 pgood", int'(pgood), int'(n >= nd));
      @(posedge clk);
    end
    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 en drop refs", int'(ref_core) + int'(ref_aux), 0);
    chk("R9 en drop flags", int'(drv_core) + int'(drv_aux) + int'(pgood), 0);
  endtask

  // abort mid-ramp by dropping por_ok
  task automatic abort_seq(input int tc);
    @(negedge clk);
    pc_core = 0; pc_aux = 0;
    tgt_core = CODE_W'(tc); tgt_aux = CODE_W'(tc); par_mode = 1'b0;
    en = 1'b1; por_ok = 1'b1;
    @(posedge clk);
    for (int n = 0; n < (DLY + 2) * CYC; n++) @(posedge clk);
    @(negedge clk);
    chk("R9 pre-abort ramp", int'(ref_core), exp_ref((DLY + 2) * CYC, tc));
    por_ok = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 por drop refs", int'(ref_core) + int'(ref_aux), 0);
    chk("R9 por drop flags", int'(drv_core) + int'(drv_aux) + int'(pgood), 0);
    en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_cnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int tv[8];
    tv = '{0, 1, 12, 13, 14, 100, 500, MAXC};
    rst_n = 1'b0; en = 1'b1; por_ok = 1'b1; par_mode = 1'b0;
    tgt_core = '0; tgt_aux = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset refs", int'(ref_core) + int'(ref_aux), 0);
    chk("R10 reset flags", int'(drv_core) + int'(drv_aux) + int'(pgood), 0);
    en = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j += 3) begin
          run_seq(tv[i], tv[j], bit'(m), 0, 0, 1'b0);
        end
      end
    end
    // pre-charge cases: mid-ramp crossing and above target
    run_seq(200, 120, 1'b0, 60, 130, 1'b0);
    run_seq(200, 120, 1'b0, 250, 40, 1'b0);
    run_seq(77, 300, 1'b1, 78, 500, 1'b0);
    run_seq(13, 26, 1'b0, 13, 26, 1'b0);
    // frozen targets and mode
    run_seq(150, 90, 1'b0, 0, 0, 1'b1);
    run_seq(60, 400, 1'b1, 20, 0, 1'b1);
    abort_seq(300);
    run_seq(40, 41, 1'b0, 0, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule